// File: doc/BRIEF.md
# MMU Access Permission Checker with Fault Status

This block is the last stage of address translation. A table walker hands it the leaf page table entry it found, or a nonzero walk error code if the walk failed. The core supplies the attributes of the access: write or read, instruction fetch or data, and user or supervisor mode. In the same cycle the block decides whether the access may proceed, and it reports whether the resulting translation may be cached with write permission.

Every fault is recorded in two registers that software can read: a fault status register and a fault address register. If a second fault arrives before software has read the first one, the status register keeps an overflow mark in place of the older fault's fields. A control bit for no-fault operation and a trap-enable flag can suppress the trap request. They never stop the registers from being updated. When software reads the status register, the block clears it.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is {acc_write, acc_exec, supervisor}, with acc_write as bit 2 and supervisor as bit 0. The permission field is leaf_pte[4:2]. With walk_err zero and req_valid high, err_code follows the fixed permission table and allow is high exactly when err_code is 0. Reads need read rights. Instruction fetches need execute rights. Writes need write rights. A write that is also a fetch needs both write and execute rights.
- R2: In user mode, permission values 6 and 7 return err_code 3 for every access type.
- R3: If fsr is nonzero when a new fault is accepted and fsr_rd is low, fsr is first replaced by 1 and the new fault's fields are then ORed in. Bit 0 therefore marks overflow, and the old fields are lost.
- R4: A fault sets fsr[7:5] to the access index, fsr[4:2] to err_code and fsr[1] to 1. The value is visible from the next clock edge.
- R5: On every fault, far takes vaddr at the next edge. far keeps its value in every cycle without a fault.
- R6: grant_write is high only when allow is high and the modified bit leaf_pte[6] is set and the permission field grants writes in the current mode. In user mode that means values 1 and 3. In supervisor mode it means 1, 3, 5 and 7.
- R7: trap_req equals fault AND traps_en AND NOT no_fault. fsr and far update on a fault even when the trap is suppressed.
- R8: When fsr_rd is high, fsr is zero after the next edge unless a fault arrives in the same cycle. A fault in that cycle loads its fields without the overflow mark.
- R9: A nonzero walk_err forces a fault with err_code equal to walk_err, whatever the permission field holds.
- R10: After reset, fsr and far are zero. While req_valid is low, allow, grant_write, trap_req and err_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| leaf_pte | input | PTE_W | Leaf entry: permission in [4:2], modified bit in [6] |
| walk_err | input | 3 | Nonzero when the walk failed; this value becomes the fault code |
| vaddr | input | VA_W | Virtual address of the access |
| acc_write | input | 1 | The access is a write |
| acc_exec | input | 1 | The access is an instruction fetch |
| supervisor | input | 1 | The access runs in supervisor mode |
| no_fault | input | 1 | Control bit that suppresses the trap |
| traps_en | input | 1 | Traps are enabled |
| fsr_rd | input | 1 | Software reads fsr this cycle |
| allow | output | 1 | The access is permitted |
| grant_write | output | 1 | The cached translation may carry write permission |
| err_code | output | 3 | Fault code: 0 allowed, 2 protection, 3 privilege, otherwise the walk code |
| trap_req | output | 1 | Request a trap for this fault |
| fsr | output | FSR_W | Fault status register |
| far | output | VA_W | Fault address register |

## Verification
A wrong permission decode shows up as a mismatch on allow or err_code in the same cycle as the access, because both are combinational. Wrong handling of the status register does not show at once. A missed overflow mark or a failed clear appears on fsr one edge after the fault or the read. A register that should have cleared but still holds a value can also hide until the next fault, when it shows as a spurious overflow bit. The reference model is therefore compared against fsr and far on every cycle, so that a stale value is caught on the edge where it first goes wrong.

// File: rtl/mmu_access_guard.sv
module mmu_access_guard #(
  parameter int VA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int PERM_LSB = 2,
  parameter int MOD_BIT  = 6,
  parameter int FSR_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PTE_W-1:0] leaf_pte,
  input  logic [2:0]       walk_err,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             acc_write,
  input  logic             acc_exec,
  input  logic             supervisor,
  input  logic             no_fault,
  input  logic             traps_en,
  input  logic             fsr_rd,
  output logic             allow,
  output logic             grant_write,
  output logic [2:0]       err_code,
  output logic             trap_req,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);

  localparam int IDX_LSB  = 5;
  localparam int CODE_LSB = 2;

  logic [2:0] perm, idx, chk_code, code;
  logic       hi, can_r, can_w, can_x, ok, fault;
  logic [FSR_W-1:0] fsr_base, fsr_next;

  assign perm  = leaf_pte[PERM_LSB +: 3];
  assign idx   = {acc_write, acc_exec, supervisor};
  assign hi    = perm[2] & perm[1];

  assign can_r = ~perm[2] | (perm == 3'd5) | (supervisor & hi);
  assign can_w = perm[0] & (~perm[2] | supervisor);
  assign can_x = (perm == 3'd2) | (perm == 3'd3) | (perm == 3'd4) | (supervisor & hi);

  always_comb begin
    if (acc_exec)       ok = can_x & (~acc_write | can_w);
    else if (acc_write) ok = can_w;
    else                ok = can_r;
  end

  assign chk_code = (~supervisor & hi) ? 3'd3 : (ok ? 3'd0 : 3'd2);
  assign code     = (walk_err != 3'd0) ? walk_err : chk_code;
  assign fault    = req_valid & (code != 3'd0);

  assign err_code    = req_valid ? code : 3'd0;
  assign allow       = req_valid & (code == 3'd0);
  assign grant_write = allow & leaf_pte[MOD_BIT] & can_w;
  assign trap_req    = fault & traps_en & ~no_fault;

  always_comb begin
    fsr_base = fsr_rd ? '0 : fsr;
    fsr_next = fsr_base;
    if (fault) begin
      fsr_next = (fsr_base != '0) ? FSR_W'(1) : '0;
      fsr_next[IDX_LSB +: 3]  = idx;
      fsr_next[CODE_LSB +: 3] = code;
      fsr_next[1]             = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr <= '0;
      far <= '0;
    end else begin
      fsr <= fsr_next;
      if (fault) far <= vaddr;
    end
  end

endmodule

module mmu_access_guard_chk #(
  parameter int VA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int PERM_LSB = 2,
  parameter int MOD_BIT  = 6,
  parameter int FSR_W    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PTE_W-1:0] leaf_pte,
  input logic [2:0]       walk_err,
  input logic [VA_W-1:0]  vaddr,
  input logic             acc_write,
  input logic             acc_exec,
  input logic             supervisor,
  input logic             no_fault,
  input logic             traps_en,
  input logic             fsr_rd,
  input logic             allow,
  input logic             grant_write,
  input logic [2:0]       err_code,
  input logic             trap_req,
  input logic [FSR_W-1:0] fsr,
  input logic [VA_W-1:0]  far
);

  logic flt;
  assign flt = req_valid & ~allow;

  p_user_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !supervisor && walk_err == 3'd0 && leaf_pte[PERM_LSB+1] && leaf_pte[PERM_LSB+2])
      |-> (!allow && err_code == 3'd3));

  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt && fsr != '0 && !fsr_rd) |=> fsr[0]);

  p_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flt |=> (fsr[1] && fsr[7:5] == $past({acc_write, acc_exec, supervisor}) && fsr[4:2] == $past(err_code)));

  p_far_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flt |=> (far == $past(vaddr)));

  p_far_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !flt |=> $stable(far));

  p_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_write |-> (allow && leaf_pte[MOD_BIT]));

  p_trap_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (no_fault || !traps_en || !req_valid) |-> !trap_req);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && !flt) |=> (fsr == '0));

  p_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && walk_err != 3'd0) |-> (!allow && err_code == walk_err));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!allow && !grant_write && err_code == 3'd0));

endmodule

bind mmu_access_guard mmu_access_guard_chk #(
  .VA_W(VA_W), .PTE_W(PTE_W), .PERM_LSB(PERM_LSB), .MOD_BIT(MOD_BIT), .FSR_W(FSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .leaf_pte(leaf_pte),
  .walk_err(walk_err), .vaddr(vaddr), .acc_write(acc_write), .acc_exec(acc_exec),
  .supervisor(supervisor), .no_fault(no_fault), .traps_en(traps_en), .fsr_rd(fsr_rd),
  .allow(allow), .grant_write(grant_write), .err_code(err_code), .trap_req(trap_req),
  .fsr(fsr), .far(far)
);

// File: tb/mmu_access_guard_tb.sv
`timescale 1ns/1ps
module mmu_access_guard_tb;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] leaf_pte = 0;
  logic [2:0]  walk_err = 0;
  logic [31:0] vaddr = 0;
  logic        acc_write = 0, acc_exec = 0, supervisor = 0;
  logic        no_fault = 0, traps_en = 0, fsr_rd = 0;
  logic        allow, grant_write, trap_req;
  logic [2:0]  err_code;
  logic [31:0] fsr, far;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_fsr = 0, m_far = 0;

  // rows: access index; nibble for permission p sits at bits [31-4p -: 4]
  localparam logic [31:0] TBL [8] = '{
    32'h00002033, 32'h00002000, 32'h22000233, 32'h22000200,
    32'h20202233, 32'h20202020, 32'h22202233, 32'h22202220 };

  always #2.5 clk = ~clk;

  mmu_access_guard u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .leaf_pte(leaf_pte),
    .walk_err(walk_err), .vaddr(vaddr), .acc_write(acc_write), .acc_exec(acc_exec),
    .supervisor(supervisor), .no_fault(no_fault), .traps_en(traps_en), .fsr_rd(fsr_rd),
    .allow(allow), .grant_write(grant_write), .err_code(err_code), .trap_req(trap_req),
    .fsr(fsr), .far(far));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: check registers, drive, check combinational outputs, advance model
  task automatic cycle(input bit v, input int perm, input bit md, input int werr,
                       input logic [31:0] va, input bit w, input bit x, input bit s,
                       input bit nf, input bit te, input bit rd);
    int idx, code, e_allow, e_grant, e_trap, e_code;
    bit wr_ok;
    @(negedge clk);
    chk("R4/R3/R8 fsr", fsr, m_fsr);
    chk("R5 far", far, m_far);
    req_valid = v; leaf_pte = 32'(perm) << 2 | (32'(md) << 6) | 32'h3;
    walk_err = 3'(werr); vaddr = va; acc_write = w; acc_exec = x; supervisor = s;
    no_fault = nf; traps_en = te; fsr_rd = rd;
    #1;
    idx  = (int'(w) << 2) | (int'(x) << 1) | int'(s);
    code = (werr != 0) ? werr : int'((TBL[idx] >> (28 - 4*perm)) & 32'hF);
    wr_ok = s ? (perm % 2 == 1) : (perm == 1 || perm == 3);
    e_code  = v ? code : 0;
    e_allow = (v && code == 0) ? 1 : 0;
    e_grant = (e_allow == 1 && md && wr_ok) ? 1 : 0;
    e_trap  = (v && code != 0 && te && !nf) ? 1 : 0;
    chk("R1/R2/R9/R10 err_code", 32'(err_code), 32'(e_code));
    chk("R1/R10 allow", 32'(allow), 32'(e_allow));
    chk("R6 grant_write", 32'(grant_write), 32'(e_grant));
    chk("R7 trap_req", 32'(trap_req), 32'(e_trap));
    if (rd) m_fsr = 0;
    if (v && code != 0) begin
      m_fsr = (m_fsr != 0) ? 32'd1 : 32'd0;
      m_fsr = m_fsr | (32'(idx) << 5) | (32'(code) << 2) | 32'd2;
      m_far = va;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R10 reset state and idle outputs
    cycle(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0);
    // R1 user data read, permission 0 allowed
    cycle(1, 0, 0, 0, 32'h1000, 0, 0, 0, 0, 1, 0);
    // R2 user read of permission 6 -> privilege fault, fsr loads
    cycle(1, 6, 0, 0, 32'hA000_1234, 0, 0, 0, 0, 1, 0);
    // R3 second fault before read -> overflow mark
    cycle(1, 4, 0, 0, 32'hB000_0040, 1, 0, 1, 0, 1, 0);
    // R8 read clears
    cycle(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 1, 1);
    cycle(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 1, 0);
    // R6 supervisor write to permission 5 with modified bit -> grant
    cycle(1, 5, 1, 0, 32'h2000, 1, 0, 1, 0, 1, 0);
    // R6 same without modified bit -> allowed, no grant
    cycle(1, 5, 0, 0, 32'h2004, 1, 0, 1, 0, 1, 0);
    // R7 user write to permission 5 with no_fault set -> fault, no trap
    cycle(1, 5, 1, 0, 32'hC000_0000, 1, 0, 0, 1, 1, 0);
    // R8 read in the same cycle as a fault -> fresh value, no overflow
    cycle(1, 0, 0, 0, 32'hD000_0008, 0, 1, 0, 0, 0, 1);
    // R9 walk error with traps enabled
    cycle(1, 3, 1, 4, 32'hE000_0010, 0, 0, 1, 0, 1, 1);
    cycle(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 1, 1);
    // full sweep of index and permission (R1, R2)
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 8; p++)
        cycle(1, p, 1, 0, 32'(i * 256 + p), i[2], i[1], i[0], 0, 1, 1);
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      cycle((r & 3) != 0, (r >> 2) & 7, r[5], (r[15:13] == 3'd7) ? ((r >> 6) & 7) : 0,
            $urandom, r[9], r[10], r[11], r[12], r[16], r[18:17] == 2'b00);
    end
    cycle(0, 0, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule